// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Tally

A single 4-bit counting stage driven by two separate strobes. A rising edge on the up strobe adds one while the down strobe rests high. A rising edge on the down strobe subtracts one while the up strobe rests high. A parameter selects the counting range: binary, 0 to 15, or decade, 0 to 9. A level-sensitive preset copies four data inputs into the count. An active-high clear forces the count to zero and overrides everything else.

Two active-low terminal outputs make wider counters. The carry output drops when the stage sits at its top value and the up strobe is low. It rises again on the strobe edge that wraps the count to zero. The borrow output behaves the same way at zero with the down strobe. To chain stages, wire carry to the next stage's up strobe and borrow to its down strobe.

The strobes are not clocks. A single system clock samples them through a two-flop synchronizer and acts on their detected rising edges. Neither strobe uses valid/ready; all pins are plain levels.

Top module: `dual_strobe_tally`

## Requirements
- R1: A rising up strobe while the synchronized down strobe is high adds one to the count. The new value appears on the third system clock edge after the port change. A rising up strobe while the down strobe is low leaves the count unchanged.
- R2: A rising down strobe while the synchronized up strobe is high subtracts one from the count, with the same latency as R1.
- R3: While load_n is low, the count takes the value of preset on every system clock, whatever the strobes do.
- R4: clr high clears the count to 0 at once, without waiting for a clock edge, and overrides load_n.
- R5: carry_n is 0 exactly when the count equals the top value and the synchronized up strobe is low. Otherwise it is 1.
- R6: borrow_n is 0 exactly when the count is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R7: The top value is 15 when DECADE=0 and 9 when DECADE=1. Counting up from the top value gives 0. Counting down from 0 gives the top value.
- R8: In decade mode, counting up from a preset value of 10 to 15 gives 0, and counting down from such a value gives 9.
- R9: If both strobes rise in the same sampled cycle, the count is unchanged.
- R10: Two decade stages chained carry to up and borrow to down count as one two-digit counter, 00 to 99, wrapping in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| clr | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Preset enable, active low |
| preset | input | WIDTH | Value loaded while load_n is low |
| up_stb | input | 1 | Count-up strobe, rests high |
| dn_stb | input | 1 | Count-down strobe, rests high |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
Increment and decrement can both be requested in one sampled cycle. The bench forces this by dropping both strobes together and then releasing them on the same clock, and it expects the count to stay put. A rising edge on one strobe while the other is held low is checked the same way. Releasing the held strobe afterwards must then make a normal single step. Clear together with preset shows that clear wins.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_LOAD = 2'd3
  } step_e;
endpackage

// File: rtl/tally_strobe_sync.sv
module tally_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic strobe,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] shift_q;
  logic              prev_q;

  // Resets to the resting-high level so release of clr yields no edge
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      shift_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], strobe};
      prev_q  <= shift_q[STAGES-1];
    end
  end

  assign level = shift_q[STAGES-1];
  assign rise  = level & ~prev_q;

  // R1: one detected edge per strobe transition
  a_r1_single_rise: assert property (@(posedge clk) disable iff (clr)
    rise |=> !rise);
endmodule

// File: rtl/tally_core.sv
module tally_core
  import tally_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TOP   = 15
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_lvl,
  input  logic             up_rise,
  input  logic             dn_lvl,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP);

  step_e            sel;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  function automatic logic [WIDTH-1:0] go_up(input logic [WIDTH-1:0] v);
    return (v >= TOP_V) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [WIDTH-1:0] go_dn(input logic [WIDTH-1:0] v);
    if (v == '0)        return TOP_V;
    else if (v > TOP_V) return TOP_V;
    else                return v - 1'b1;
  endfunction

  always_comb begin
    if (!load_n)                             sel = STEP_LOAD;
    else if (up_rise && !dn_rise && dn_lvl)  sel = STEP_UP;
    else if (dn_rise && !up_rise && up_lvl)  sel = STEP_DN;
    else                                     sel = STEP_HOLD;
  end

  always_comb begin
    unique case (sel)
      STEP_LOAD: cnt_d = preset;
      STEP_UP:   cnt_d = go_up(cnt_q);
      STEP_DN:   cnt_d = go_dn(cnt_q);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r1_up_step: assert property (@(posedge clk) disable iff (clr)
    (load_n && up_rise && !dn_rise && dn_lvl) |=>
      count == (($past(count) >= TOP_V) ? '0 : $past(count) + 1'b1));

  a_r2_dn_step: assert property (@(posedge clk) disable iff (clr)
    (load_n && dn_rise && !up_rise && up_lvl && $past(1'b1)) |=>
      (count <= TOP_V) && (count != $past(count)));

  a_r3_load: assert property (@(posedge clk) disable iff (clr)
    !load_n |=> count == $past(preset));

  a_r8_legal_after_step: assert property (@(posedge clk) disable iff (clr)
    (load_n && (up_rise || dn_rise)) |=> count <= TOP_V);

  a_r9_both_hold: assert property (@(posedge clk) disable iff (clr)
    (load_n && up_rise && dn_rise) |=> $stable(count));
endmodule

// File: rtl/dual_strobe_tally.sv
module dual_strobe_tally #(
  parameter int WIDTH   = 4,
  parameter bit DECADE  = 1'b0,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int               TOP_I = DECADE ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] TOP_V = WIDTH'(TOP_I);

  logic [1:0] lvl;
  logic [1:0] rise;
  logic [1:0] raw;

  assign raw = {dn_stb, up_stb};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tally_strobe_sync #(.STAGES(SYNC_FF)) u_sync (
      .clk    (clk),
      .clr    (clr),
      .strobe (raw[g]),
      .level  (lvl[g]),
      .rise   (rise[g])
    );
  end

  tally_core #(.WIDTH(WIDTH), .TOP(TOP_I)) u_core (
    .clk     (clk),
    .clr     (clr),
    .load_n  (load_n),
    .preset  (preset),
    .up_lvl  (lvl[0]),
    .up_rise (rise[0]),
    .dn_lvl  (lvl[1]),
    .dn_rise (rise[1]),
    .count   (count)
  );

  assign carry_n  = !((count == TOP_V) && !lvl[0]);
  assign borrow_n = !((count == '0)    && !lvl[1]);

  a_r5_carry_at_top: assert property (@(posedge clk) disable iff (clr)
    !carry_n |-> (count == TOP_V));

  a_r6_borrow_at_zero: assert property (@(posedge clk) disable iff (clr)
    !borrow_n |-> (count == '0));

  a_r4_clear_now: assert property (@(posedge clk)
    clr |-> (count == '0));
endmodule

// File: tb/tb_dual_strobe_tally.sv
module tb_dual_strobe_tally;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // binary single stage
  logic       b_clr = 1'b1, b_ld_n = 1'b1, b_up = 1'b1, b_dn = 1'b1;
  logic [3:0] b_pre = '0;
  logic [3:0] b_cnt;
  logic       b_cy, b_bw;

  dual_strobe_tally #(.WIDTH(4), .DECADE(1'b0)) dut (
    .clk(clk), .clr(b_clr), .load_n(b_ld_n), .preset(b_pre),
    .up_stb(b_up), .dn_stb(b_dn), .count(b_cnt),
    .carry_n(b_cy), .borrow_n(b_bw));

  // decade two-stage chain
  logic       d_clr = 1'b1, d_ld_n = 1'b1, d_up = 1'b1, d_dn = 1'b1;
  logic [3:0] lo_pre = '0, hi_pre = '0;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_cy, lo_bw, hi_cy, hi_bw;

  dual_strobe_tally #(.WIDTH(4), .DECADE(1'b1)) dut_lo (
    .clk(clk), .clr(d_clr), .load_n(d_ld_n), .preset(lo_pre),
    .up_stb(d_up), .dn_stb(d_dn), .count(lo_cnt),
    .carry_n(lo_cy), .borrow_n(lo_bw));

  dual_strobe_tally #(.WIDTH(4), .DECADE(1'b1)) dut_hi (
    .clk(clk), .clr(d_clr), .load_n(d_ld_n), .preset(hi_pre),
    .up_stb(lo_cy), .dn_stb(lo_bw), .count(hi_cnt),
    .carry_n(hi_cy), .borrow_n(hi_bw));

  function automatic int m_up(int v, int top);
    return (v >= top) ? 0 : v + 1;
  endfunction

  function automatic int m_dn(int v, int top);
    if (v == 0) return top;
    if (v > top) return top;
    return v - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrap_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    wrap_up();
  end

  int exp_b;
  int exp_d;

  task automatic b_up_pulse();
    b_up = 1'b0; tick(5);
    chk("R5 carry", b_cy, (exp_b == 15) ? 0 : 1);
    b_up = 1'b1; tick(5);
    exp_b = m_up(exp_b, 15);
    chk("R1/R7 up", b_cnt, exp_b);
    chk("R5 carry idle", b_cy, 1);
  endtask

  task automatic b_dn_pulse();
    b_dn = 1'b0; tick(5);
    chk("R6 borrow", b_bw, (exp_b == 0) ? 0 : 1);
    b_dn = 1'b1; tick(5);
    exp_b = m_dn(exp_b, 15);
    chk("R2/R7 down", b_cnt, exp_b);
  endtask

  task automatic d_step(bit up);
    if (up) d_up = 1'b0; else d_dn = 1'b0;
    tick(8);
    if (up) d_up = 1'b1; else d_dn = 1'b1;
    tick(12);
    exp_d = up ? (exp_d + 1) % 100 : (exp_d + 99) % 100;
    chk("R10 chain", 10 * hi_cnt + lo_cnt, exp_d);
  endtask

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk("R4 reset count", b_cnt, 0);
    chk("R5 reset carry", b_cy, 1);
    chk("R6 reset borrow", b_bw, 1);
    b_clr = 1'b0; d_clr = 1'b0;
    exp_b = 0;
    tick(3);

    // directed wraps R7
    b_dn_pulse();
    chk("R7 wrap down to 15", b_cnt, 15);
    b_up_pulse();
    chk("R7 wrap up to 0", b_cnt, 0);

    // directed simultaneous R9
    b_up = 1'b0; b_dn = 1'b0; tick(5);
    b_up = 1'b1; b_dn = 1'b1; tick(6);
    chk("R9 both strobes hold", b_cnt, exp_b);

    // random mix
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0, 1: b_up_pulse();
        2, 3: b_dn_pulse();
        4: begin
          b_pre = 4'($urandom);
          b_ld_n = 1'b0; b_up = 1'b0; tick(3);
          b_up = 1'b1; tick(3);
          chk("R3 load ignores strobe", b_cnt, b_pre);
          b_ld_n = 1'b1; tick(2);
          exp_b = b_pre;
          chk("R3 load held", b_cnt, exp_b);
        end
        5: begin
          b_pre = 4'($urandom | 1);
          b_ld_n = 1'b0; b_clr = 1'b1; #1;
          chk("R4 async clear", b_cnt, 0);
          tick(3);
          chk("R4 clear over load", b_cnt, 0);
          b_clr = 1'b0; b_ld_n = 1'b1; tick(3);
          exp_b = 0;
          chk("R4 after clear", b_cnt, 0);
        end
        default: begin
          if ($urandom % 2) begin
            b_up = 1'b0; b_dn = 1'b0; tick(5);
            b_up = 1'b1; b_dn = 1'b1; tick(6);
            chk("R9 both strobes hold", b_cnt, exp_b);
          end else begin
            b_dn = 1'b0; tick(4);
            b_up = 1'b0; tick(4);
            b_up = 1'b1; tick(6);
            chk("R1 up gated by low down", b_cnt, exp_b);
            b_dn = 1'b1; tick(6);
            exp_b = m_dn(exp_b, 15);
            chk("R2 down after release", b_cnt, exp_b);
          end
        end
      endcase
    end

    // decade illegal presets R8
    lo_pre = 4'd12; hi_pre = 4'd3;
    d_ld_n = 1'b0; tick(2); d_ld_n = 1'b1; tick(2);
    chk("R8 illegal loaded", lo_cnt, 12);
    d_up = 1'b0; tick(8); d_up = 1'b1; tick(12);
    chk("R8 illegal up to 0", lo_cnt, 0);
    chk("R8 high digit untouched", hi_cnt, 3);
    lo_pre = 4'd14;
    d_ld_n = 1'b0; tick(2); d_ld_n = 1'b1; tick(2);
    d_dn = 1'b0; tick(8); d_dn = 1'b1; tick(12);
    chk("R8 illegal down to 9", lo_cnt, 9);
    chk("R8 high digit untouched", hi_cnt, 3);

    // chain R10
    lo_pre = 4'd5; hi_pre = 4'd9;
    d_ld_n = 1'b0; tick(2); d_ld_n = 1'b1; tick(2);
    exp_d = 95;
    chk("R10 chain load", 10 * hi_cnt + lo_cnt, 95);
    for (int i = 0; i < 8; i++) d_step(1'b1);
    for (int i = 0; i < 10; i++) d_step(1'b0);
    for (int i = 0; i < 30; i++) d_step(1'($urandom));
    d_dn = 1'b0; tick(8);
    chk("R6 chain borrow", lo_bw, (lo_cnt == 0) ? 0 : 1);
    d_dn = 1'b1; tick(12);
    exp_d = (exp_d + 99) % 100;
    chk("R10 chain final", 10 * hi_cnt + lo_cnt, exp_d);

    wrap_up();
  end
endmodule